// File: doc/BRIEF.md
# Rotation-Aware Display RAM Window Addresser

This block sits between a drawing engine and the command port of a 320x240 display controller. It accepts one of three requests: a drawing window, a cursor position, or a change of orientation. For each request it produces the ordered register writes the controller needs.

Windows and cursors arrive in logical coordinates. The block mirrors them against the panel size, according to the orientation that is in effect, to form physical RAM addresses. It packs the vertical end and start rows into one register word and writes the horizontal limits as two separate words. A cursor request ends with the index of the pixel-data register, so that pixel data can follow at once.

Each register write leaves as two beats on a valid/ready command port: an index beat, then a data beat. A done pulse marks the end of each request. The block also reports the logical width and height that the current orientation gives.

Top module: `gram_window_addresser`

## Requirements
- R1: After reset, `cmd_ready` is 1, `wr_valid` is 0, `done` is 0, `orient_q` is 0, `log_width` is 320 and `log_height` is 240.
- R2: A window request (`cmd_op`=0) emits six beats in this order: index 0x44, vertical word, index 0x45, horizontal start, index 0x46, horizontal end. An index beat has `wr_data_phase`=0, carries the index in `wr_word[7:0]` and has zeros above it. A data beat has `wr_data_phase`=1.
- R3: A cursor request (`cmd_op`=1) emits five beats in this order: index 0x4E, X data, index 0x4F, Y data, then index 0x22 as an index beat with no data beat after it.
- R4: The cursor address (X, Y) is (x, y) at orientation 0, (y, 239−x) at 1, (319−x, 239−y) at 2 and (319−y, x) at 3. X is masked to 9 bits and Y to 8 bits.
- R5: The window words are formed as follows. The vertical word holds the end row in bits 15:8 and the start row in bits 7:0. The horizontal words are masked to 9 bits. At orientation 0: rows y..y+h−1, columns x..x+w−1. At 1: rows 240−(x+w)..239−x, columns y..y+h−1. At 2: rows 240−(y+h)..239−y, columns 320−(x+w)..319−x. At 3: rows x..x+w−1, columns 320−(y+h)..319−y.
- R6: An orientation request (`cmd_op`=2) for a new code emits index 0x11 and then the entry word. The entry word is 0x6830 for code 0, 0x6818 for 1, 0x6800 for 2 and 0x6828 for 3. `orient_q` takes the new code in the cycle after acceptance.
- R7: An orientation request for the code already in effect emits no beats and pulses `done` in the cycle after acceptance.
- R8: At orientations 1 and 3, `log_width` is 240 and `log_height` is 320. At orientations 0 and 2 they are 320 and 240.
- R9: While `wr_valid` is 1 and `wr_ready` is 0, the current beat (`wr_word`, `wr_data_phase`) holds unchanged.
- R10: `cmd_ready` is 0 while beats remain. `done` is 1 for exactly the cycle after the final beat's handshake, and the next request may be accepted in that cycle.
- R11: Operation code 3 is accepted, emits no beats and pulses `done` in the cycle after acceptance.
- R12: Window and cursor requests are remapped with the orientation in effect when they are accepted, including an orientation set by the request just before them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request may be accepted |
| cmd_op | input | 2 | 0 window, 1 cursor, 2 orientation, 3 no operation |
| cmd_x | input | CW | Logical x |
| cmd_y | input | CW | Logical y |
| cmd_w | input | CW | Window width |
| cmd_h | input | CW | Window height |
| cmd_orient | input | 2 | Requested orientation code |
| wr_valid | output | 1 | Command beat present |
| wr_ready | input | 1 | Command beat taken |
| wr_data_phase | output | 1 | 0 index beat, 1 data beat |
| wr_word | output | 16 | Beat payload |
| done | output | 1 | One-cycle end-of-request pulse |
| orient_q | output | 2 | Orientation in effect |
| log_width | output | CW | Logical width |
| log_height | output | CW | Logical height |

## Verification
The bench walks through all four orientations. Under each one it issues windows and cursors, and it includes cases where mirroring goes below zero, such as a cursor at x=300 at orientation 1. A design that masks too late, or masks to the wrong width, writes a wrong Y byte in that case. It repeats an orientation request and issues the spare operation code. A design that treats these as real requests emits stray entry-mode writes or never pulses done. The bench withholds `wr_ready` on a repeating pattern, so that a sequencer that advances on valid alone would skip or repeat beats. It also sends a window right after an orientation change, which shows whether remapping uses a stale orientation.

// File: rtl/wa_pkg.sv
package wa_pkg;
  typedef enum logic [1:0] {
    OP_WINDOW = 2'd0,
    OP_CURSOR = 2'd1,
    OP_ORIENT = 2'd2,
    OP_NONE   = 2'd3
  } wa_op_e;

  localparam int MAX_BEATS = 6;
  localparam int WORD_W    = 16;

  // scan-direction word per orientation code
  function automatic logic [15:0] entry_word(input logic [1:0] o);
    case (o)
      2'd0:    entry_word = 16'h6830;
      2'd1:    entry_word = 16'h6818;
      2'd2:    entry_word = 16'h6800;
      default: entry_word = 16'h6828;
    endcase
  endfunction
endpackage

// File: rtl/wa_rst_sync.sv
module wa_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/wa_remap.sv
module wa_remap #(
  parameter int PANEL_W = 320,
  parameter int PANEL_H = 240,
  parameter int CW      = 9
) (
  input  logic [1:0]    orient,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] w,
  input  logic [CW-1:0] h,
  output logic [15:0]   vpos_word,
  output logic [15:0]   hstart_word,
  output logic [15:0]   hend_word,
  output logic [15:0]   curx_word,
  output logic [15:0]   cury_word
);
  localparam logic [15:0] PW   = 16'(PANEL_W);
  localparam logic [15:0] PH   = 16'(PANEL_H);
  localparam logic [15:0] PW_M = 16'(PANEL_W - 1);
  localparam logic [15:0] PH_M = 16'(PANEL_H - 1);

  logic [15:0] x16, y16, xend, yend, xlim, ylim;
  logic [15:0] vs, ve, hs, he, cx, cy;

  always_comb begin
    x16  = 16'(x);
    y16  = 16'(y);
    xend = x16 + 16'(w) - 16'd1;
    yend = y16 + 16'(h) - 16'd1;
    xlim = x16 + 16'(w);
    ylim = y16 + 16'(h);
    case (orient)
      2'd0: begin
        vs = y16;          ve = yend;
        hs = x16;          he = xend;
        cx = x16;          cy = y16;
      end
      2'd1: begin
        vs = PH - xlim;    ve = PH_M - x16;
        hs = y16;          he = yend;
        cx = y16;          cy = PH_M - x16;
      end
      2'd2: begin
        vs = PH - ylim;    ve = PH_M - y16;
        hs = PW - xlim;    he = PW_M - x16;
        cx = PW_M - x16;   cy = PH_M - y16;
      end
      default: begin
        vs = x16;          ve = xend;
        hs = PW - ylim;    he = PW_M - y16;
        cx = PW_M - y16;   cy = x16;
      end
    endcase
    vpos_word   = {ve[7:0], vs[7:0]};
    hstart_word = {7'd0, hs[8:0]};
    hend_word   = {7'd0, he[8:0]};
    curx_word   = {7'd0, cx[8:0]};
    cury_word   = {8'd0, cy[7:0]};
  end
endmodule

// File: rtl/wa_seq.sv
module wa_seq #(
  parameter int DEPTH = 6,
  parameter int WW    = 16,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [NW-1:0]             ld_cnt,
  input  logic [DEPTH-1:0]          ld_ph,
  input  logic [DEPTH-1:0][WW-1:0]  ld_word,
  output logic                      busy,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic                      out_ph,
  output logic [WW-1:0]             out_word,
  output logic                      done
);
  logic [DEPTH-1:0]         ph_q, ph_d;
  logic [DEPTH-1:0][WW-1:0] word_q, word_d;
  logic [NW-1:0]            cnt_q, cnt_d, ptr_q, ptr_d;
  logic                     done_q, done_d;
  logic                     adv_en, ld_en;

  assign busy      = (ptr_q != cnt_q);
  assign out_valid = busy;
  assign adv_en    = busy & out_ready;
  assign ld_en     = load & ~busy;

  always_comb begin
    ph_d   = ph_q;
    word_d = word_q;
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    done_d = 1'b0;
    if (ld_en) begin
      ph_d   = ld_ph;
      word_d = ld_word;
      cnt_d  = ld_cnt;
      ptr_d  = '0;
      done_d = (ld_cnt == '0);
    end else if (adv_en) begin
      ptr_d  = ptr_q + 1'b1;
      done_d = (ptr_d == cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      word_q <= '0;
      cnt_q  <= '0;
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      word_q <= word_d;
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  logic [DEPTH-1:0]         sel;
  logic [DEPTH-1:0][WW-1:0] masked;
  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign sel[i]    = busy && (ptr_q == NW'(i));
    assign masked[i] = sel[i] ? word_q[i] : '0;
  end

  always_comb begin
    out_word = '0;
    out_ph   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      out_word = out_word | masked[i];
      out_ph   = out_ph | (sel[i] & ph_q[i]);
    end
  end
endmodule

// File: rtl/gram_window_addresser.sv
module gram_window_addresser #(
  parameter int         PANEL_W     = 320,
  parameter int         PANEL_H     = 240,
  parameter int         CW          = 9,
  parameter logic [7:0] IDX_VPOS    = 8'h44,
  parameter logic [7:0] IDX_HSTART  = 8'h45,
  parameter logic [7:0] IDX_HEND    = 8'h46,
  parameter logic [7:0] IDX_XADDR   = 8'h4E,
  parameter logic [7:0] IDX_YADDR   = 8'h4F,
  parameter logic [7:0] IDX_RAMDATA = 8'h22,
  parameter logic [7:0] IDX_ENTRY   = 8'h11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [CW-1:0] cmd_x,
  input  logic [CW-1:0] cmd_y,
  input  logic [CW-1:0] cmd_w,
  input  logic [CW-1:0] cmd_h,
  input  logic [1:0]    cmd_orient,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic          wr_data_phase,
  output logic [15:0]   wr_word,
  output logic          done,
  output logic [1:0]    orient_q,
  output logic [CW-1:0] log_width,
  output logic [CW-1:0] log_height
);
  import wa_pkg::*;

  localparam int DEPTH = MAX_BEATS;
  localparam int NW    = $clog2(DEPTH + 1);

  logic srst_n;
  wa_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  logic busy, accept, orient_en;
  logic [1:0] orient_d;
  wa_op_e op;

  assign op        = wa_op_e'(cmd_op);
  assign cmd_ready = ~busy;
  assign accept    = cmd_valid & ~busy;
  assign orient_en = accept & (op == OP_ORIENT);

  always_comb begin
    orient_d = orient_q;
    if (orient_en) orient_d = cmd_orient;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) orient_q <= 2'd0;
    else         orient_q <= orient_d;
  end

  assign log_width  = orient_q[0] ? CW'(PANEL_H) : CW'(PANEL_W);
  assign log_height = orient_q[0] ? CW'(PANEL_W) : CW'(PANEL_H);

  logic [15:0] vpos_w, hs_w, he_w, cx_w, cy_w;
  wa_remap #(.PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .CW(CW)) u_remap (
    .orient(orient_q), .x(cmd_x), .y(cmd_y), .w(cmd_w), .h(cmd_h),
    .vpos_word(vpos_w), .hstart_word(hs_w), .hend_word(he_w),
    .curx_word(cx_w), .cury_word(cy_w)
  );

  logic [NW-1:0]                ld_cnt;
  logic [DEPTH-1:0]             ld_ph;
  logic [DEPTH-1:0][WORD_W-1:0] ld_word;

  always_comb begin
    ld_cnt  = '0;
    ld_ph   = '0;
    ld_word = '0;
    case (op)
      OP_WINDOW: begin
        ld_cnt     = NW'(6);
        ld_ph      = 6'b101010;
        ld_word[0] = {8'd0, IDX_VPOS};
        ld_word[1] = vpos_w;
        ld_word[2] = {8'd0, IDX_HSTART};
        ld_word[3] = hs_w;
        ld_word[4] = {8'd0, IDX_HEND};
        ld_word[5] = he_w;
      end
      OP_CURSOR: begin
        ld_cnt     = NW'(5);
        ld_ph      = 6'b001010;
        ld_word[0] = {8'd0, IDX_XADDR};
        ld_word[1] = cx_w;
        ld_word[2] = {8'd0, IDX_YADDR};
        ld_word[3] = cy_w;
        ld_word[4] = {8'd0, IDX_RAMDATA};
      end
      OP_ORIENT: begin
        if (cmd_orient != orient_q) begin
          ld_cnt     = NW'(2);
          ld_ph      = 6'b000010;
          ld_word[0] = {8'd0, IDX_ENTRY};
          ld_word[1] = entry_word(cmd_orient);
        end
      end
      default: ;
    endcase
  end

  wa_seq #(.DEPTH(DEPTH), .WW(WORD_W)) u_seq (
    .clk(clk), .rst_n(srst_n), .load(accept), .ld_cnt(ld_cnt),
    .ld_ph(ld_ph), .ld_word(ld_word), .busy(busy),
    .out_valid(wr_valid), .out_ready(wr_ready),
    .out_ph(wr_data_phase), .out_word(wr_word), .done(done)
  );
endmodule

// File: rtl/wa_chk.sv
module wa_chk #(
  parameter int PANEL_W = 320,
  parameter int PANEL_H = 240,
  parameter int CW      = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          wr_data_phase,
  input logic [15:0]   wr_word,
  input logic          done,
  input logic [1:0]    orient_q,
  input logic [CW-1:0] log_width,
  input logic [CW-1:0] log_height
);
  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_word) && $stable(wr_data_phase)));

  // R10
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && wr_valid));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && !wr_valid));

  // R2
  index_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_data_phase) |-> (wr_word[15:8] == 8'd0));

  // R12
  orient_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready && cmd_op == 2'd2) |=> $stable(orient_q));

  // R8
  dims_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    orient_q[0] |-> (log_width < log_height));

  // R8
  dims_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(log_width) + 32'(log_height)) == (PANEL_W + PANEL_H));
endmodule

bind gram_window_addresser wa_chk #(.PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data_phase(wr_data_phase), .wr_word(wr_word), .done(done),
  .orient_q(orient_q), .log_width(log_width), .log_height(log_height)
);

// File: tb/sim_gram_window_addresser.sv
module sim_gram_window_addresser;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 9;
  localparam int PW = 320;
  localparam int PH = 240;

  logic clk, rst_n, cmd_valid, cmd_ready, wr_valid, wr_ready, wr_data_phase, done;
  logic [1:0] cmd_op, cmd_orient, orient_q;
  logic [CW-1:0] cmd_x, cmd_y, cmd_w, cmd_h, log_width, log_height;
  logic [15:0] wr_word;

  gram_window_addresser u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_w(cmd_w), .cmd_h(cmd_h),
    .cmd_orient(cmd_orient), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data_phase(wr_data_phase), .wr_word(wr_word), .done(done),
    .orient_q(orient_q), .log_width(log_width), .log_height(log_height)
  );

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;
  int stall_mode = 0;

  int    q_ph[$];
  int    q_w[$];
  string q_tag[$];
  int    m_or = 0;
  bit    m_done = 0;
  string m_done_tag = "R10";
  bit    stalled_last = 0;

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void push(input int ph, input int w, input string tag);
    q_ph.push_back(ph);
    q_w.push_back(w);
    q_tag.push_back(tag);
  endfunction

  function automatic void model_accept(input int op, input int x, input int y,
                                       input int w, input int h, input int o);
    int vs, ve, hs, he, cx, cy;
    vs = 0; ve = 0; hs = 0; he = 0; cx = 0; cy = 0;
    case (m_or)
      0: begin vs = y; ve = y+h-1; hs = x; he = x+w-1; cx = x; cy = y; end
      1: begin vs = PH-(x+w); ve = PH-1-x; hs = y; he = y+h-1; cx = y; cy = PH-1-x; end
      2: begin vs = PH-(y+h); ve = PH-1-y; hs = PW-(x+w); he = PW-1-x; cx = PW-1-x; cy = PH-1-y; end
      default: begin vs = x; ve = x+w-1; hs = PW-(y+h); he = PW-1-y; cx = PW-1-y; cy = x; end
    endcase
    case (op)
      0: begin // R2 ordering, R5 / R12 values
        push(0, 'h44, "R2"); push(1, ((ve & 'hFF) << 8) | (vs & 'hFF), "R5/R12");
        push(0, 'h45, "R2"); push(1, hs & 'h1FF, "R5/R12");
        push(0, 'h46, "R2"); push(1, he & 'h1FF, "R5/R12");
      end
      1: begin // R3 ordering, R4 / R12 values
        push(0, 'h4E, "R3"); push(1, cx & 'h1FF, "R4/R12");
        push(0, 'h4F, "R3"); push(1, cy & 'hFF, "R4/R12");
        push(0, 'h22, "R3");
      end
      2: begin
        if (o != m_or) begin
          push(0, 'h11, "R6");
          case (o)
            0: push(1, 'h6830, "R6");
            1: push(1, 'h6818, "R6");
            2: push(1, 'h6800, "R6");
            default: push(1, 'h6828, "R6");
          endcase
          m_or = o;
        end else m_done_tag = "R7";
      end
      default: m_done_tag = "R11";
    endcase
  endfunction

  // compare and advance the reference model away from the clock edge
  always @(negedge clk) begin
    if (chk_on) begin
      bit nd;
      bit rdy_now;
      string tg;
      chk(cmd_ready, q_ph.size() == 0, "R10 cmd_ready");
      chk(wr_valid, q_ph.size() != 0, "R10 wr_valid");
      if (q_ph.size() != 0) begin
        tg = stalled_last ? "R9" : q_tag[0];
        chk(wr_data_phase, q_ph[0], tg);
        chk(wr_word, q_w[0], tg);
      end
      chk(done, m_done, m_done_tag);
      chk(orient_q, m_or, "R6 orient");
      chk(log_width,  (m_or % 2) ? PH : PW, "R8 width");
      chk(log_height, (m_or % 2) ? PW : PH, "R8 height");

      nd = 0;
      rdy_now = (q_ph.size() == 0);
      stalled_last = (q_ph.size() != 0) && !wr_ready;
      if (q_ph.size() != 0 && wr_ready) begin
        void'(q_ph.pop_front()); void'(q_w.pop_front()); void'(q_tag.pop_front());
        if (q_ph.size() == 0) begin nd = 1; m_done_tag = "R10"; end
      end
      if (rdy_now && cmd_valid) begin
        m_done_tag = "R10";
        model_accept(cmd_op, cmd_x, cmd_y, cmd_w, cmd_h, cmd_orient);
        if (q_ph.size() == 0) nd = 1;
      end
      m_done = nd;
    end
  end

  // ready pattern: always ready, or withheld every third cycle
  initial begin
    int cyc = 0;
    wr_ready = 1;
    forever begin
      @(posedge clk); #1;
      wr_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      cyc++;
    end
  end

  task automatic send(input int op, input int x, input int y, input int w,
                      input int h, input int o);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_op = 2'(op);
    cmd_x = CW'(x); cmd_y = CW'(y); cmd_w = CW'(w); cmd_h = CW'(h);
    cmd_orient = 2'(o);
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_orient = 0;
    cmd_x = 0; cmd_y = 0; cmd_w = 0; cmd_h = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready, 1, "R1 cmd_ready");
    chk(wr_valid, 0, "R1 wr_valid");
    chk(done, 0, "R1 done");
    chk(orient_q, 0, "R1 orient");
    chk(log_width, PW, "R1 width");
    chk(log_height, PH, "R1 height");
    chk_on = 1;

    send(0, 10, 20, 30, 40, 0);
    send(1, 5, 7, 0, 0, 0);
    send(2, 0, 0, 0, 0, 0);        // R7 same orientation
    send(3, 0, 0, 0, 0, 0);        // R11 spare op
    stall_mode = 1;                 // R9 stalls from here
    send(2, 0, 0, 0, 0, 1);
    send(0, 10, 20, 30, 40, 0);    // R12 uses new orientation
    send(1, 300, 100, 0, 0, 0);    // R4 masking of negative Y
    send(2, 0, 0, 0, 0, 2);
    send(0, 0, 0, 320, 240, 0);    // R5 full panel
    send(1, 0, 0, 0, 0, 0);
    send(2, 0, 0, 0, 0, 3);
    send(0, 50, 60, 70, 80, 0);
    send(1, 12, 34, 0, 0, 0);
    send(2, 0, 0, 0, 0, 3);        // R7 again
    send(2, 0, 0, 0, 0, 0);
    send(1, 319, 239, 0, 0, 0);
    stall_mode = 0;
    send(0, 100, 50, 1, 1, 0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(q_ph.size(), 0, "R10 drained");
    finish_run();
  end
endmodule